// File: doc/BRIEF.md
# Serial-bus wiper setting slave

This block is a two-wire serial-bus slave that owns a 6-bit wiper code. It runs on a fast system clock and oversamples the bus clock and data lines, so every bus event is seen a few system cycles after it occurs on the wires. A host selects the block with a 7-bit address. Six of those bits are fixed and the seventh comes from a strap input, which lets two copies share one bus.

A write carries an instruction byte and then one or more data bytes. Each data byte loads a new wiper code. The top bit of the instruction byte asks the external fuse sequencer to make the setting permanent. The block signals that request with a single one-cycle pulse.

A read returns one byte: the two validation status bits from the sequencer, followed by the wiper code. Once the status reports a completed burn, written codes no longer reach the wiper. The block drives the data line only through an open-drain enable.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the wiper code is 0x20, the data-line enable is released and the program request is low.
- R2: The slave address is 7 bits, sent MSB first: 0,1,0,1,1,0 and then the strap input, followed by the R/W bit (0 = write, 1 = read). On a match the slave pulls SDA low during the 9th clock pulse. On a mismatch it does not acknowledge, and the rest of that transaction has no effect.
- R3: In a write, the byte after the address is the instruction byte and every later byte is a data byte. The slave acknowledges each of them, and the low six bits of each data byte become the wiper code. Bits 7:6 of a data byte are ignored.
- R4: Within one write, every additional data byte loads its own code into the wiper.
- R5: When bit 7 of the instruction byte is 1, exactly one program request pulse is raised per write. The pulse is one system clock wide and comes at the end of the acknowledge of the first data byte. When that bit is 0, no pulse is raised.
- R6: In a read, right after the address acknowledge, the slave shifts out one byte MSB first: status[1], status[0], then wiper bits 5..0. It then releases SDA so the master can drive the acknowledge bit.
- R7: While the status input is 2'b11 (burn complete), data bytes are still acknowledged, but the wiper keeps its value and no program request is raised.
- R8: A START seen anywhere, including in the middle of a byte, restarts address reception from bit 0. A STOP returns the slave to idle.
- R9: The data-line enable changes only while the synchronised bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 1 | Low address bit taken from a board strap |
| status_i | input | 2 | Validation status from the fuse sequencer (11 = burned) |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper_o | output | 6 | Current wiper code |
| prog_req_o | output | 1 | One-cycle request to start the permanent burn |

## Verification
A bit counter that has lost its place in the byte shows up as a missing or misplaced acknowledge on the very next byte. It also appears as a wiper code shifted by one bit, which can be read back within the same or the next transaction. A wrong state after a data byte appears as an extra or missing program pulse inside a window of a few system clocks. A wrong locking decision leaves the wiper changed after a write that should have had no effect, which the next read exposes.

// File: rtl/wpi_pkg.sv
package wpi_pkg;
  localparam int CODE_W = 6;
  localparam int STAT_W = 2;
  localparam int BYTE_W = CODE_W + STAT_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD, ST_RD_ACK
  } wpi_state_e;

  function automatic logic [BYTE_W-1:0] pack_read(input logic [STAT_W-1:0] st,
                                                  input logic [CODE_W-1:0] code);
    return {st, code};
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-2:0] got,
                                    input logic [BYTE_W-3:0] prefix,
                                    input logic strap);
    return got == {prefix, strap};
  endfunction

  function automatic logic is_burned(input logic [STAT_W-1:0] st);
    return &st;
  endfunction
endpackage

// File: rtl/wpi_line_sync.sv
module wpi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-1:0], pin_i};
  end

  assign lvl_o  = q[STAGES-1];
  assign rise_o =  q[STAGES-1] & ~q[STAGES];
  assign fall_o = ~q[STAGES-1] &  q[STAGES];
endmodule

// File: rtl/wpi_proto_fsm.sv
module wpi_proto_fsm
  import wpi_pkg::*;
#(
  parameter logic [BYTE_W-3:0] ADDR_PREFIX = 6'b010110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              strap,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              load_evt,
  output logic              prog_evt,
  output logic [CODE_W-1:0] code
);
  wpi_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              rw_q;
  logic              t_q;
  logic              full;
  logic              quiet;

  assign full  = (cnt == CNT_W'(BYTE_W));
  assign quiet = !start_evt && !stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      rw_q <= 1'b0; t_q <= 1'b0; sda_oe <= 1'b0;
    end else if (start_evt) begin
      st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st <= ST_IDLE; cnt <= '0; sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          sh  <= {sh[BYTE_W-2:0], sda_lvl};
          cnt <= cnt + 1'b1;
        end
        ST_RD:     cnt <= cnt + 1'b1;
        ST_RD_ACK: st  <= ST_IDLE;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        ST_ADDR: if (full) begin
          if (addr_hit(sh[BYTE_W-1:1], ADDR_PREFIX, strap)) begin
            sda_oe <= 1'b1; rw_q <= sh[0]; st <= ST_ADDR_ACK;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_INSTR: if (full) begin
          sda_oe <= 1'b1; t_q <= sh[BYTE_W-1]; st <= ST_INSTR_ACK;
        end
        ST_DATA: if (full) begin
          sda_oe <= 1'b1; st <= ST_DATA_ACK;
        end
        ST_ADDR_ACK: begin
          cnt <= '0;
          if (rw_q) begin
            tx <= rd_byte; sda_oe <= ~rd_byte[BYTE_W-1]; st <= ST_RD;
          end else begin
            sda_oe <= 1'b0; st <= ST_INSTR;
          end
        end
        ST_INSTR_ACK, ST_DATA_ACK: begin
          sda_oe <= 1'b0; cnt <= '0; st <= ST_DATA;
        end
        ST_RD: if (full) begin
          sda_oe <= 1'b0; st <= ST_RD_ACK;
        end else begin
          tx <= {tx[BYTE_W-2:0], 1'b0}; sda_oe <= ~tx[BYTE_W-2];
        end
        default: ;
      endcase
    end
  end

  assign load_evt = quiet && scl_fall && (st == ST_DATA) && full;
  assign prog_evt = quiet && scl_fall && (st == ST_DATA_ACK) && t_q;
  assign code     = sh[CODE_W-1:0];
endmodule

// File: rtl/wpi_wiper_reg.sv
module wpi_wiper_reg
  import wpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              load_evt,
  input  logic              prog_evt,
  input  logic              burned,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] wiper,
  output logic              prog_req
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  logic fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper <= MID; fired <= 1'b0; prog_req <= 1'b0;
    end else begin
      prog_req <= 1'b0;
      if (start_evt) fired <= 1'b0;
      if (load_evt && !burned) wiper <= code;
      if (prog_evt && !burned && !fired) begin
        prog_req <= 1'b1; fired <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wpi_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-3:0] ADDR_PREFIX = 6'b010110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic [CODE_W-1:0] wiper_o,
  output logic              prog_req_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_evt, stop_evt, load_evt, prog_evt;
  logic [CODE_W-1:0] code;

  wpi_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .pin_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  wpi_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .pin_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start_evt = scl_lvl && !scl_rise && sda_fall;
  assign stop_evt  = scl_lvl && !scl_rise && sda_rise;

  wpi_proto_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .strap(strap_i), .rd_byte(pack_read(status_i, wiper_o)),
    .sda_oe(sda_oe_o), .load_evt(load_evt), .prog_evt(prog_evt), .code(code));

  wpi_wiper_reg u_wip (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .load_evt(load_evt),
    .prog_evt(prog_evt), .burned(is_burned(status_i)), .code(code),
    .wiper(wiper_o), .prog_req(prog_req_o));
endmodule

// File: rtl/wpi_chk.sv
module wpi_chk
  import wpi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              sda_oe,
  input logic              load_evt,
  input logic              prog_req,
  input logic [STAT_W-1:0] status,
  input logic [CODE_W-1:0] wiper
);
  // R9
  oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));

  // R5
  prog_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  // R7
  prog_not_when_burned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> ($past(status) != 2'b11));

  // R7
  wiper_frozen_burned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) == 2'b11) |-> $stable(wiper));

  // R3
  wiper_moves_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> $past(load_evt));
endmodule

bind wiper_i2c_slave wpi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe_o),
  .load_evt(load_evt), .prog_req(prog_req_o), .status(status_i),
  .wiper(wiper_o));

// File: tb/wiper_i2c_slave_tb.sv
module wiper_i2c_slave_tb;
  localparam int CLK_NS = 10;
  localparam int Q      = 8;
  localparam int NVEC   = 6;
  // [15] address ok, [14] T, [13:8] code, [5:0] expected wiper
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 6'h3F, 2'b00, 6'h3F},
    {1'b1, 1'b0, 6'h00, 2'b00, 6'h00},
    {1'b0, 1'b0, 6'h11, 2'b00, 6'h00},
    {1'b1, 1'b1, 6'h2A, 2'b00, 6'h2A},
    {1'b1, 1'b0, 6'h15, 2'b00, 6'h15},
    {1'b0, 1'b1, 6'h07, 2'b00, 6'h15}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic strap = 1'b1;
  logic [1:0] status = 2'b00;
  logic sda_oe, prog_req;
  logic [5:0] wiper;
  wire sda_line = m_sda & ~sda_oe;
  int total = 0, bad = 0, pulses = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) if (prog_req) pulses <= pulses + 1;

  wiper_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .status_i(status), .sda_oe_o(sda_oe), .wiper_o(wiper), .prog_req_o(prog_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0; qw();
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
  endtask
  task automatic put_bit(input logic b);
    m_sda = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask
  task automatic get_bit(output logic b);
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); b = sda_line; qw(); scl = 1'b0; qw();
  endtask
  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic get_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(1'b1);
  endtask

  function automatic logic [7:0] addr(input logic s, input logic rd);
    return {6'b010110, s, rd};
  endfunction

  task automatic do_read(input string req, input logic [7:0] exp);
    logic ack; logic [7:0] v;
    bus_start(); put_byte(addr(strap, 1'b1), ack);
    check({req, " read addr ack"}, ack, 1'b1);
    get_byte(v); bus_stop();
    check({req, " read byte"}, v, exp);
    check({req, " sda released after read"}, sda_oe, 1'b0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    int p0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 wiper", wiper, 6'h20);
    check("R1 oe", sda_oe, 1'b0);
    check("R1 prog", prog_req, 1'b0);
    rst_n = 1'b1; qw();
    check("R1 wiper after release", wiper, 6'h20);
    do_read("R6 R1 midscale", {2'b00, 6'h20});

    // table walk: R2 R3 R5
    for (int k = 0; k < NVEC; k++) begin
      logic ok, t; logic [5:0] c, e;
      {ok, t, c} = VEC[k][15:8]; e = VEC[k][5:0];
      p0 = pulses;
      bus_start();
      put_byte(addr(ok ? strap : ~strap, 1'b0), ack);
      check("R2 address ack", ack, ok);
      put_byte({t, 7'h55}, ack);
      if (ok) check("R3 instr ack", ack, 1'b1);
      put_byte({2'b11, c}, ack);
      if (ok) check("R3 data ack", ack, 1'b1);
      bus_stop();
      check("R3 wiper", wiper, e);
      check("R5 pulse count", pulses - p0, (ok && t) ? 1 : 0);
      do_read("R6 table", {2'b00, e});
    end

    // R4 several data bytes
    bus_start(); put_byte(addr(strap, 1'b0), ack); put_byte(8'h00, ack);
    for (int v = 1; v <= 3; v++) begin
      put_byte(8'(v), ack);
      check("R4 repeated data ack", ack, 1'b1);
      check("R4 repeated data wiper", wiper, 6'(v));
    end
    bus_stop();

    // R5 one pulse for several bytes with T=1
    p0 = pulses;
    bus_start(); put_byte(addr(strap, 1'b0), ack); put_byte(8'h80, ack);
    put_byte(8'h0A, ack); put_byte(8'h0B, ack); bus_stop();
    check("R5 single pulse per write", pulses - p0, 1);
    check("R4 last byte wins", wiper, 6'h0B);

    // R6 status bits in read byte
    status = 2'b10; qw();
    do_read("R6 status", {2'b10, 6'h0B});

    // R7 burned: no change, no pulse, still acked
    status = 2'b11; qw();
    p0 = pulses;
    bus_start(); put_byte(addr(strap, 1'b0), ack); put_byte(8'h80, ack);
    put_byte(8'h09, ack);
    check("R7 data ack when burned", ack, 1'b1);
    bus_stop();
    check("R7 wiper frozen", wiper, 6'h0B);
    check("R7 no pulse", pulses - p0, 0);
    do_read("R7 R6 burned read", {2'b11, 6'h0B});
    status = 2'b00; qw();

    // R8 START mid-byte restarts address reception
    bus_start(); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_start(); put_byte(addr(strap, 1'b0), ack);
    check("R8 ack after restart", ack, 1'b1);
    put_byte(8'h00, ack); put_byte(8'h15, ack); bus_stop();
    check("R8 wiper after restart", wiper, 6'h15);
    check("R8 idle after stop", sda_oe, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule